// File: doc/BRIEF.md
# Dual-Group Bus Transceiver Enable Control

This block is the control core of a bidirectional buffer with two independent 9-bit groups. Each group has an active-low enable pin and a direction pin. The block turns these into two active-high drive enables per group, one for the A side and one for the B side. It also forwards each group's data in the selected direction without inversion. The tri-state ports are modelled as separate data-out and drive-enable signals, so the block contains no tri-state nets.

Each group has a small power-up gate state machine. Its states are `GATE_LOCKED`, `GATE_ARMED` and `GATE_LIVE`, and its transitions are:

- LOCKED to ARMED: taken on a clock edge that samples the group's enable pin high.
- ARMED to LIVE: taken on a later edge that samples the pin low.
- LIVE stays LIVE until reset.
- Reset (asynchronous, active low) forces LOCKED from any state.

Outputs of a group can be driven only in LIVE. A test-control input lets boundary-scan logic replace all drive enables and output data with its own update values.

Top module: `xcvr_enable_ctrl`

## Requirements
- R1: Straight after reset, with test control off, every drive enable (`a_oe`, `b_oe`) is 0 and every output data bit is 0. This holds whatever the pins hold.
- R2: A gate in LOCKED keeps its group disabled while the enable pin stays low, for any number of cycles.
- R3: A group can drive only after its gate has passed through ARMED and entered LIVE. ARMED is entered on an edge that samples the pin high, and LIVE on a later edge that samples it low. Drive starts right after the edge that enters LIVE.
- R4: In LIVE, an enable pin at 1 turns both of that group's drive enables off at once, whatever the direction. Returning the pin to 0 re-enables the group without a new edge sequence.
- R5: In LIVE with the pin at 0, direction 1 sets `b_oe`=1 and `b_out` equal to `a_in`. Direction 0 sets `a_oe`=1 and `a_out` equal to `b_in`. The data is not inverted.
- R6: With test control off, the data output of any side whose drive enable is 0 reads 0.
- R7: The groups are independent. Group 0 owns bits 8..0 and enable/direction bit 0, and group 1 owns bits 17..9 and bit 1. The pins and gate of one group do not change the other group's outputs.
- R8: Asserting reset again returns both gates to LOCKED, so the outputs are disabled even with the pins held low.
- R9: With `tst_en`=1, `a_oe`, `b_oe`, `a_out` and `b_out` equal `tst_a_oe`, `tst_b_oe`, `tst_a_out` and `tst_b_out`, whatever the gate state.
- R10: With test control off, `a_oe` and `b_oe` of one group are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the power-up gates |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_oe_n | input | 2 | Active-low enable pin per group |
| grp_dir | input | 2 | Direction per group, 1 = A to B |
| a_in | input | 18 | A-side input data |
| b_in | input | 18 | B-side input data |
| a_out | output | 18 | A-side output data |
| b_out | output | 18 | B-side output data |
| a_oe | output | 2 | A-side drive enable per group |
| b_oe | output | 2 | B-side drive enable per group |
| tst_en | input | 1 | Test control override |
| tst_a_oe | input | 2 | Test value for A drive enables |
| tst_b_oe | input | 2 | Test value for B drive enables |
| tst_a_out | input | 18 | Test value for A output data |
| tst_b_out | input | 18 | Test value for B output data |

## Verification
Only the gate transitions take time. A gate moves one state per clock edge, so a group becomes drivable one edge after its low pin is sampled in ARMED. Everything else is combinational: the enable-pin, direction, data and test-override effects appear in the same cycle as the stimulus. The bench drives inputs one time unit after a rising edge and samples one unit later for combinational results. For gate transitions it waits exactly one further edge, and it checks the ARMED state before that edge to confirm the output is still off.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    typedef enum logic [1:0] {
        GATE_LOCKED = 2'd0,
        GATE_ARMED  = 2'd1,
        GATE_LIVE   = 2'd2
    } gate_state_t;
endpackage

// File: rtl/xcvr_pwrup_gate.sv
module xcvr_pwrup_gate
    import xcvr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    output logic live
);
    gate_state_t state_q;
    gate_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GATE_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_LOCKED: if (oe_n)  state_d = GATE_ARMED;
            GATE_ARMED:  if (!oe_n) state_d = GATE_LIVE;
            GATE_LIVE:   state_d = GATE_LIVE;
            default:     state_d = GATE_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        live = (state_q == GATE_LIVE);
    end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
    parameter int WIDTH = 9
) (
    input  logic             live,
    input  logic             oe_n,
    input  logic             dir,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             tst_en,
    input  logic             tst_a_oe,
    input  logic             tst_b_oe,
    input  logic [WIDTH-1:0] tst_a_out,
    input  logic [WIDTH-1:0] tst_b_out,
    output logic             a_oe,
    output logic             b_oe,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] b_out
);
    logic pass;
    logic drive_a;
    logic drive_b;

    always_comb begin
        pass    = live & ~oe_n;
        drive_a = pass & ~dir;
        drive_b = pass & dir;
        if (tst_en) begin
            a_oe  = tst_a_oe;
            b_oe  = tst_b_oe;
            a_out = tst_a_out;
            b_out = tst_b_out;
        end else begin
            a_oe  = drive_a;
            b_oe  = drive_b;
            a_out = drive_a ? b_in : '0;
            b_out = drive_b ? a_in : '0;
        end
    end
endmodule

// File: rtl/xcvr_enable_ctrl.sv
module xcvr_enable_ctrl #(
    parameter int GROUPS = 2,
    parameter int WIDTH  = 9,
    localparam int BUS_W = GROUPS * WIDTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GROUPS-1:0] grp_oe_n,
    input  logic [GROUPS-1:0] grp_dir,
    input  logic [BUS_W-1:0]  a_in,
    input  logic [BUS_W-1:0]  b_in,
    output logic [BUS_W-1:0]  a_out,
    output logic [BUS_W-1:0]  b_out,
    output logic [GROUPS-1:0] a_oe,
    output logic [GROUPS-1:0] b_oe,
    input  logic              tst_en,
    input  logic [GROUPS-1:0] tst_a_oe,
    input  logic [GROUPS-1:0] tst_b_oe,
    input  logic [BUS_W-1:0]  tst_a_out,
    input  logic [BUS_W-1:0]  tst_b_out
);
    logic [GROUPS-1:0] live;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        xcvr_pwrup_gate u_gate (
            .clk   (clk),
            .rst_n (rst_n),
            .oe_n  (grp_oe_n[g]),
            .live  (live[g])
        );

        xcvr_lane #(.WIDTH(WIDTH)) u_lane (
            .live      (live[g]),
            .oe_n      (grp_oe_n[g]),
            .dir       (grp_dir[g]),
            .a_in      (a_in[g*WIDTH +: WIDTH]),
            .b_in      (b_in[g*WIDTH +: WIDTH]),
            .tst_en    (tst_en),
            .tst_a_oe  (tst_a_oe[g]),
            .tst_b_oe  (tst_b_oe[g]),
            .tst_a_out (tst_a_out[g*WIDTH +: WIDTH]),
            .tst_b_out (tst_b_out[g*WIDTH +: WIDTH]),
            .a_oe      (a_oe[g]),
            .b_oe      (b_oe[g]),
            .a_out     (a_out[g*WIDTH +: WIDTH]),
            .b_out     (b_out[g*WIDTH +: WIDTH])
        );
    end
endmodule

// File: rtl/xcvr_enable_ctrl_chk.sv
module xcvr_enable_ctrl_chk #(
    parameter int GROUPS = 2,
    parameter int WIDTH  = 9,
    localparam int BUS_W = GROUPS * WIDTH
) (
    input logic              clk,
    input logic              rst_n,
    input logic [GROUPS-1:0] grp_oe_n,
    input logic [BUS_W-1:0]  a_in,
    input logic [BUS_W-1:0]  b_in,
    input logic [BUS_W-1:0]  a_out,
    input logic [BUS_W-1:0]  b_out,
    input logic [GROUPS-1:0] a_oe,
    input logic [GROUPS-1:0] b_oe,
    input logic              tst_en,
    input logic [GROUPS-1:0] tst_a_oe,
    input logic [GROUPS-1:0] tst_b_oe,
    input logic [BUS_W-1:0]  tst_a_out,
    input logic [BUS_W-1:0]  tst_b_out
);
    logic [GROUPS-1:0] seen_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_hi <= '0;
        end else begin
            seen_hi <= seen_hi | grp_oe_n;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && !tst_en) |-> (a_oe == '0 && b_oe == '0)); // R1

    AST_NEEDS_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        !tst_en |-> (((a_oe | b_oe) & ~seen_hi) == '0)); // R3

    AST_PIN_HIGH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !tst_en |-> (((a_oe | b_oe) & grp_oe_n) == '0)); // R4

    AST_SIDES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !tst_en |-> ((a_oe & b_oe) == '0)); // R10

    AST_TEST_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        tst_en |-> (a_oe == tst_a_oe && b_oe == tst_b_oe &&
                    a_out == tst_a_out && b_out == tst_b_out)); // R9

    for (genvar g = 0; g < GROUPS; g++) begin : g_chk
        AST_B_FOLLOWS_A: assert property (@(posedge clk) disable iff (!rst_n)
            (!tst_en && b_oe[g]) |-> (b_out[g*WIDTH +: WIDTH] == a_in[g*WIDTH +: WIDTH])); // R5
        AST_A_FOLLOWS_B: assert property (@(posedge clk) disable iff (!rst_n)
            (!tst_en && a_oe[g]) |-> (a_out[g*WIDTH +: WIDTH] == b_in[g*WIDTH +: WIDTH])); // R5
        AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (!tst_en && !a_oe[g] && !b_oe[g]) |->
            (a_out[g*WIDTH +: WIDTH] == '0 && b_out[g*WIDTH +: WIDTH] == '0)); // R6
    end
endmodule

bind xcvr_enable_ctrl xcvr_enable_ctrl_chk #(.GROUPS(GROUPS), .WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .grp_oe_n  (grp_oe_n),
    .a_in      (a_in),
    .b_in      (b_in),
    .a_out     (a_out),
    .b_out     (b_out),
    .a_oe      (a_oe),
    .b_oe      (b_oe),
    .tst_en    (tst_en),
    .tst_a_oe  (tst_a_oe),
    .tst_b_oe  (tst_b_oe),
    .tst_a_out (tst_a_out),
    .tst_b_out (tst_b_out)
);

// File: tb/xcvr_enable_ctrl_test.sv
`timescale 1ns/1ps
module xcvr_enable_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  grp_oe_n;
    logic [1:0]  grp_dir;
    logic [17:0] a_in, b_in;
    logic [17:0] a_out, b_out;
    logic [1:0]  a_oe, b_oe;
    logic        tst_en;
    logic [1:0]  tst_a_oe, tst_b_oe;
    logic [17:0] tst_a_out, tst_b_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    xcvr_enable_ctrl uut (
        .clk(clk), .rst_n(rst_n), .grp_oe_n(grp_oe_n), .grp_dir(grp_dir),
        .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
        .a_oe(a_oe), .b_oe(b_oe), .tst_en(tst_en), .tst_a_oe(tst_a_oe),
        .tst_b_oe(tst_b_oe), .tst_a_out(tst_a_out), .tst_b_out(tst_b_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        settle();
    endtask

    task automatic t_reset_quiet();
        grp_oe_n = 2'b00; grp_dir = 2'b11;
        a_in = 18'h2A5C3; b_in = 18'h15A3C;
        do_reset();
        check("R1 oe after reset", {a_oe, b_oe}, 4'h0);
        check("R1 data after reset", {a_out, b_out}, 36'h0);
        for (int i = 0; i < 6; i++) step();
        check("R2 locked with pin low", {a_oe, b_oe}, 4'h0);
        check("R2 locked data", b_out, 18'h0);
    endtask

    task automatic t_open_g0();
        grp_dir = 2'b11;
        grp_oe_n[0] = 1'b1;
        step();
        grp_oe_n[0] = 1'b0;
        settle();
        check("R3 armed still off", {a_oe, b_oe}, 4'h0);
        step();
        check("R3 live drives B", b_oe, 2'b01);
        check("R5 b_out = a_in grp0", b_out[8:0], a_in[8:0]);
        check("R7 grp1 untouched", {a_oe[1], b_oe[1], a_out[17:9], b_out[17:9]}, 20'h0);
        check("R6 idle A side zero", a_out[8:0], 9'h0);
    endtask

    task automatic t_dir_patterns();
        for (int i = 0; i < 4; i++) begin
            a_in = 18'h3FFFF ^ (18'h1234 << i);
            b_in = 18'h0F0F0 + 18'(i * 37);
            grp_dir[0] = i[0];
            settle();
            if (i[0]) begin
                check("R5 dir1 b_out", b_out[8:0], a_in[8:0]);
                check("R6 dir1 a_out zero", a_out[8:0], 9'h0);
            end else begin
                check("R5 dir0 a_out", a_out[8:0], b_in[8:0]);
                check("R6 dir0 b_out zero", b_out[8:0], 9'h0);
            end
            check("R10 exclusive", a_oe[0] & b_oe[0], 1'b0);
            step();
        end
    endtask

    task automatic t_pin_high();
        for (int d = 0; d < 2; d++) begin
            grp_dir[0] = d[0];
            grp_oe_n[0] = 1'b1;
            settle();
            check("R4 pin high off", {a_oe[0], b_oe[0]}, 2'b00);
            check("R4 pin high data", {a_out[8:0], b_out[8:0]}, 18'h0);
            step();
            grp_oe_n[0] = 1'b0;
            settle();
            check("R4 re-enable", {a_oe[0], b_oe[0]}, d[0] ? 2'b01 : 2'b10);
        end
    endtask

    task automatic t_open_g1();
        grp_dir = 2'b01;
        grp_oe_n[1] = 1'b1;
        step();
        grp_oe_n[1] = 1'b0;
        settle();
        check("R3 grp1 armed off", {a_oe[1], b_oe[1]}, 2'b00);
        step();
        check("R7 grp1 B to A", {a_oe[1], b_oe[1]}, 2'b10);
        check("R5 grp1 a_out", a_out[17:9], b_in[17:9]);
        check("R7 grp0 still A to B", {a_oe[0], b_oe[0]}, 2'b01);
        grp_oe_n[0] = 1'b1;
        settle();
        check("R7 grp1 unaffected by grp0 pin", a_out[17:9], b_in[17:9]);
        grp_oe_n[0] = 1'b0;
        step();
    endtask

    task automatic t_test_override();
        tst_en = 1'b1;
        tst_a_oe = 2'b10; tst_b_oe = 2'b01;
        tst_a_out = 18'h3C3C3; tst_b_out = 18'h0A5A5;
        settle();
        check("R9 oe override", {a_oe, b_oe}, {tst_a_oe, tst_b_oe});
        check("R9 a data override", a_out, tst_a_out);
        check("R9 b data override", b_out, tst_b_out);
        tst_en = 1'b0;
        settle();
    endtask

    task automatic t_reset_again();
        grp_oe_n = 2'b00;
        do_reset();
        check("R8 disabled after new reset", {a_oe, b_oe}, 4'h0);
        step();
        step();
        check("R8 stays locked", {a_oe, b_oe}, 4'h0);
        t_test_override();
        check("R9 off restores locked", {a_oe, b_oe}, 4'h0);
    endtask

    initial begin
        rst_n = 1'b0; grp_oe_n = 2'b00; grp_dir = 2'b00;
        a_in = '0; b_in = '0; tst_en = 1'b0;
        tst_a_oe = '0; tst_b_oe = '0; tst_a_out = '0; tst_b_out = '0;
        t_reset_quiet();
        t_open_g0();
        t_dir_patterns();
        grp_dir[0] = 1'b1;
        t_pin_high();
        t_open_g1();
        t_test_override();
        t_reset_again();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule